// File: doc/BRIEF.md
# Masked Row-to-Row Bit Transfer Unit

This block models the storage of a rectangular array of elements, NCOL columns by NROW rows. Each element holds one user state bit and a small memory of DEPTH bits, addressed one bit at a time. In a single clock cycle the unit copies one bit per column from a chosen source row to one or more destination rows. Either side of the move can be a row of element state bits or a row of memory bits. For the memory side, a bit address picks the same bit position in every memory of that row.

Configured logic drives the operands straight onto the ports: a source row index, a source side, a destination row bitmap, a destination side, a bit address and a column mask, plus a strobe that fires the transfer. A column whose mask bit is clear keeps its old destination value. A load port writes a whole row word at a time, so the array can be seeded. A zero-latency read port lets configured logic observe any row word.

Top module: `rowbit_xfer`

## Requirements
- R1: After reset every element state bit and every memory bit reads 0.
- R2: When `ld_valid` is 1 and `xfer_go` is 0, the word `ld_word` replaces the row word selected by `ld_row`, `ld_kind` (0 = state bits, 1 = memory) and `ld_addr` at the next clock edge. No other storage changes.
- R3: A transfer with `src_kind` = 0 takes bit c of its source word from the state bit of column c in row `src_row`.
- R4: A transfer with `src_kind` = 1 takes bit c of its source word from bit `bit_addr` of the memory in column c of row `src_row`.
- R5: In every destination row, column c takes the source bit only when `col_mask[c]` is 1. A column whose mask bit is 0 keeps its value.
- R6: A transfer writes, in the same cycle, every row r whose bit `dst_rows[r]` is 1. Rows whose bit is 0 are left unchanged on both sides.
- R7: With `dst_kind` = 1, only bit `bit_addr` of each destination memory changes. Other bit positions and the state bits of that row keep their values.
- R8: The source is sampled before the cycle's writes. A transfer issued in the cycle right after another one sees the earlier transfer's result.
- R9: When `xfer_go` and `ld_valid` are both 1 in the same cycle, the transfer is performed and the load is dropped.
- R10: `rd_word` shows, with no clock delay, the current row word selected by `rd_row`, `rd_kind` and `rd_addr`.
- R11: A transfer with an all-zero `dst_rows` or an all-zero `col_mask`, or a cycle with neither strobe, changes no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_go | input | 1 | Performs one row-to-row transfer this cycle |
| src_row | input | ROW_W | Source row index |
| src_kind | input | 1 | Source side: 0 state bits, 1 memory |
| dst_rows | input | NROW | Destination row bitmap |
| dst_kind | input | 1 | Destination side: 0 state bits, 1 memory |
| bit_addr | input | ADDR_W | Bit position used in every memory touched |
| col_mask | input | NCOL | Columns that take part in the transfer |
| ld_valid | input | 1 | Writes a full row word |
| ld_row | input | ROW_W | Row written by the load |
| ld_kind | input | 1 | Side written by the load |
| ld_addr | input | ADDR_W | Memory bit position written by the load |
| ld_word | input | NCOL | Word written by the load |
| rd_row | input | ROW_W | Row observed on the read port |
| rd_kind | input | 1 | Side observed on the read port |
| rd_addr | input | ADDR_W | Memory bit position observed |
| rd_word | output | NCOL | Current contents of the observed row word |

## Verification
The bench seeds the array with distinct words. It then checks four kinds of corner: a partial mask, where a design that ignored the mask would overwrite columns it must keep; a multi-row bitmap, where writing only the lowest set row or touching unselected rows shows up as wrong row words; a memory destination next to preloaded neighbour addresses, which exposes a write that spills over the whole memory or into the state bits; and back-to-back transfers chained through one row, which catch a stale source path. It also fires a load and a transfer together, to check that the load is dropped, and issues transfers with an empty bitmap or an empty mask, which must leave every word as it was.

// File: rtl/rowbit_pkg.sv
package rowbit_pkg;

    // Which storage plane of a row an operand refers to.
    typedef enum logic {
        SIDE_LOGIC = 1'b0,
        SIDE_MEM   = 1'b1
    } side_e;

    function automatic logic side_is_mem(input logic kind);
        return side_e'(kind) == SIDE_MEM;
    endfunction

endpackage

// File: rtl/rowbit_word_pick.sv
// Selects one NCOL-wide row word out of the array: either the state bits
// of a row, or one bit position across every memory of that row.
module rowbit_word_pick
    import rowbit_pkg::*;
#(
    parameter int NROW  = 8,
    parameter int NCOL  = 8,
    parameter int DEPTH = 64,
    localparam int ROW_W  = (NROW  > 1) ? $clog2(NROW)  : 1,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [NROW-1:0][NCOL-1:0]            lb_rows,
    input  logic [NROW-1:0][DEPTH-1:0][NCOL-1:0] mem_rows,
    input  logic [ROW_W-1:0]                     row,
    input  logic                                 kind,
    input  logic [ADDR_W-1:0]                    addr,
    output logic [NCOL-1:0]                      word
);

    logic [NCOL-1:0] lb_word;
    logic [NCOL-1:0] mem_word;

    always_comb begin
        lb_word  = lb_rows[row];
        mem_word = mem_rows[row][addr];
        word     = side_is_mem(kind) ? mem_word : lb_word;
    end

endmodule

// File: rtl/rowbit_lane_merge.sv
// Per-row masked merge: column c of row r takes the source bit when both
// the row is selected and the column mask bit is set.
module rowbit_lane_merge #(
    parameter int NROW = 8,
    parameter int NCOL = 8
) (
    input  logic [NROW-1:0][NCOL-1:0] old_rows,
    input  logic [NCOL-1:0]           src_word,
    input  logic [NCOL-1:0]           col_mask,
    input  logic [NROW-1:0]           row_sel,
    output logic [NROW-1:0][NCOL-1:0] new_rows
);

    for (genvar r = 0; r < NROW; r++) begin : g_row
        logic [NCOL-1:0] eff_mask;
        always_comb begin
            eff_mask    = col_mask & {NCOL{row_sel[r]}};
            new_rows[r] = (old_rows[r] & ~eff_mask) | (src_word & eff_mask);
        end
    end

endmodule

// File: rtl/rowbit_xfer.sv
// Masked row-to-row bit transfer unit over an array of state bits and
// bit-addressable memories. One transfer per cycle, read-before-write.
module rowbit_xfer
    import rowbit_pkg::*;
#(
    parameter int NROW  = 8,
    parameter int NCOL  = 8,
    parameter int DEPTH = 64,
    localparam int ROW_W  = (NROW  > 1) ? $clog2(NROW)  : 1,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_go,
    input  logic [ROW_W-1:0]  src_row,
    input  logic              src_kind,
    input  logic [NROW-1:0]   dst_rows,
    input  logic              dst_kind,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic [NCOL-1:0]   col_mask,
    input  logic              ld_valid,
    input  logic [ROW_W-1:0]  ld_row,
    input  logic              ld_kind,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [NCOL-1:0]   ld_word,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic              rd_kind,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NCOL-1:0]   rd_word
);

    typedef struct packed {
        logic [NROW-1:0][DEPTH-1:0][NCOL-1:0] mem;
        logic [NROW-1:0][NCOL-1:0]            lb;
    } array_t;

    array_t st_d, st_q;

    // Source word, taken from the registered state (read-before-write).
    logic [NCOL-1:0] src_word;

    rowbit_word_pick #(.NROW(NROW), .NCOL(NCOL), .DEPTH(DEPTH)) src_pick_i (
        .lb_rows  (st_q.lb),
        .mem_rows (st_q.mem),
        .row      (src_row),
        .kind     (src_kind),
        .addr     (bit_addr),
        .word     (src_word)
    );

    rowbit_word_pick #(.NROW(NROW), .NCOL(NCOL), .DEPTH(DEPTH)) rd_pick_i (
        .lb_rows  (st_q.lb),
        .mem_rows (st_q.mem),
        .row      (rd_row),
        .kind     (rd_kind),
        .addr     (rd_addr),
        .word     (rd_word)
    );

    // Gather the addressed bit position of every memory row.
    logic [NROW-1:0][NCOL-1:0] mem_slice;
    for (genvar r = 0; r < NROW; r++) begin : g_slice
        assign mem_slice[r] = st_q.mem[r][bit_addr];
    end

    // Row-select vectors per destination plane.
    logic [NROW-1:0] sel_lb;
    logic [NROW-1:0] sel_mem;
    always_comb begin
        sel_lb  = side_is_mem(dst_kind) ? '0 : dst_rows;
        sel_mem = side_is_mem(dst_kind) ? dst_rows : '0;
    end

    logic [NROW-1:0][NCOL-1:0] lb_merged;
    logic [NROW-1:0][NCOL-1:0] mem_merged;

    rowbit_lane_merge #(.NROW(NROW), .NCOL(NCOL)) lb_merge_i (
        .old_rows (st_q.lb),
        .src_word (src_word),
        .col_mask (col_mask),
        .row_sel  (sel_lb),
        .new_rows (lb_merged)
    );

    rowbit_lane_merge #(.NROW(NROW), .NCOL(NCOL)) mem_merge_i (
        .old_rows (mem_slice),
        .src_word (src_word),
        .col_mask (col_mask),
        .row_sel  (sel_mem),
        .new_rows (mem_merged)
    );

    // Next-state computation: transfer has priority over the load port.
    always_comb begin
        st_d = st_q;
        if (xfer_go) begin
            st_d.lb = lb_merged;
            for (int r = 0; r < NROW; r++) begin
                st_d.mem[r][bit_addr] = mem_merged[r];
            end
        end else if (ld_valid) begin
            if (side_is_mem(ld_kind)) begin
                st_d.mem[ld_row][ld_addr] = ld_word;
            end else begin
                st_d.lb[ld_row] = ld_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rowbit_xfer_chk.sv
module rowbit_xfer_chk #(
    parameter int NROW  = 8,
    parameter int NCOL  = 8,
    parameter int DEPTH = 64,
    localparam int ROW_W  = (NROW  > 1) ? $clog2(NROW)  : 1,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 xfer_go,
    input  logic [ROW_W-1:0]                     src_row,
    input  logic                                 src_kind,
    input  logic [NROW-1:0]                      dst_rows,
    input  logic                                 dst_kind,
    input  logic [ADDR_W-1:0]                    bit_addr,
    input  logic [NCOL-1:0]                      col_mask,
    input  logic                                 ld_valid,
    input  logic [NROW-1:0][NCOL-1:0]            lb_q,
    input  logic [NROW-1:0][DEPTH-1:0][NCOL-1:0] mem_q
);

    // R1: the first cycle out of reset sees a cleared array.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lb_q == '0 && mem_q == '0));

    // R11: a cycle with no strobe leaves all storage alone.
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_go && !ld_valid) |=> ($stable(lb_q) && $stable(mem_q)));

    for (genvar r = 0; r < NROW; r++) begin : g_row
        // R6 / R9: a row outside the bitmap is untouched, load or not.
        assert_unselected_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_go && !dst_rows[r]) |=> ($stable(lb_q[r]) && $stable(mem_q[r])));

        // R5: masked-off columns of a selected state row keep their value.
        assert_mask_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_go && !dst_kind && dst_rows[r])
            |=> (((lb_q[r] ^ $past(lb_q[r])) & ~$past(col_mask)) == '0));

        // R3: state row to state row carries the source row's bits.
        assert_lb_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_go && !src_kind && !dst_kind && dst_rows[r])
            |=> ((lb_q[r] & $past(col_mask)) == ($past(lb_q[src_row]) & $past(col_mask))));

        // R4: memory row to state row carries the addressed memory bits.
        assert_mem_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_go && src_kind && !dst_kind && dst_rows[r])
            |=> ((lb_q[r] & $past(col_mask))
                 == ($past(mem_q[src_row][bit_addr]) & $past(col_mask))));

        // R7: a memory destination never touches the row's state bits.
        assert_mem_dst_lb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_go && dst_kind && dst_rows[r]) |=> $stable(lb_q[r]));
    end

endmodule

bind rowbit_xfer rowbit_xfer_chk #(.NROW(NROW), .NCOL(NCOL), .DEPTH(DEPTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_go  (xfer_go),
    .src_row  (src_row),
    .src_kind (src_kind),
    .dst_rows (dst_rows),
    .dst_kind (dst_kind),
    .bit_addr (bit_addr),
    .col_mask (col_mask),
    .ld_valid (ld_valid),
    .lb_q     (st_q.lb),
    .mem_q    (st_q.mem)
);

// File: tb/rowbit_xfer_tb_top.sv
`timescale 1ns/1ps
module rowbit_xfer_tb_top;

    localparam int NROW   = 8;
    localparam int NCOL   = 8;
    localparam int DEPTH  = 64;
    localparam int ROW_W  = $clog2(NROW);
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xfer_go = 1'b0;
    logic [ROW_W-1:0]  src_row = '0;
    logic              src_kind = 1'b0;
    logic [NROW-1:0]   dst_rows = '0;
    logic              dst_kind = 1'b0;
    logic [ADDR_W-1:0] bit_addr = '0;
    logic [NCOL-1:0]   col_mask = '0;
    logic              ld_valid = 1'b0;
    logic [ROW_W-1:0]  ld_row = '0;
    logic              ld_kind = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [NCOL-1:0]   ld_word = '0;
    logic [ROW_W-1:0]  rd_row = '0;
    logic              rd_kind = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [NCOL-1:0]   rd_word;

    always #4 clk = ~clk;

    rowbit_xfer #(.NROW(NROW), .NCOL(NCOL), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_go(xfer_go), .src_row(src_row),
        .src_kind(src_kind), .dst_rows(dst_rows), .dst_kind(dst_kind),
        .bit_addr(bit_addr), .col_mask(col_mask), .ld_valid(ld_valid),
        .ld_row(ld_row), .ld_kind(ld_kind), .ld_addr(ld_addr),
        .ld_word(ld_word), .rd_row(rd_row), .rd_kind(rd_kind),
        .rd_addr(rd_addr), .rd_word(rd_word)
    );

    // Reference model of the array.
    logic [NCOL-1:0] ref_lb  [NROW];
    logic [NCOL-1:0] ref_mem [NROW][DEPTH];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic cmp(input logic [NCOL-1:0] act, input logic [NCOL-1:0] exp,
                       input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R10: read port observation, no clock needed.
    task automatic peek(input logic kind, input int row, input int addr,
                        input logic [NCOL-1:0] exp, input string tag);
        rd_kind = kind;
        rd_row  = ROW_W'(row);
        rd_addr = ADDR_W'(addr);
        #1;
        cmp(rd_word, exp, tag);
    endtask

    task automatic check_lb_all(input string tag);
        for (int r = 0; r < NROW; r++) peek(1'b0, r, 0, ref_lb[r], tag);
    endtask

    task automatic check_mem_at(input int addr, input string tag);
        for (int r = 0; r < NROW; r++) peek(1'b1, r, addr, ref_mem[r][addr], tag);
    endtask

    task automatic load(input logic kind, input int row, input int addr,
                        input logic [NCOL-1:0] w);
        @(negedge clk);
        ld_valid = 1'b1; ld_kind = kind; ld_row = ROW_W'(row);
        ld_addr = ADDR_W'(addr); ld_word = w;
        @(negedge clk);
        ld_valid = 1'b0;
        if (kind) ref_mem[row][addr] = w; else ref_lb[row] = w;
    endtask

    function automatic logic [NCOL-1:0] ref_src(input logic sk, input int sr,
                                                input int addr);
        return sk ? ref_mem[sr][addr] : ref_lb[sr];
    endfunction

    task automatic apply_ref(input logic sk, input int sr, input logic dk,
                             input logic [NROW-1:0] dr, input int addr,
                             input logic [NCOL-1:0] m);
        logic [NCOL-1:0] s;
        s = ref_src(sk, sr, addr);
        for (int r = 0; r < NROW; r++) begin
            if (dr[r]) begin
                if (dk) ref_mem[r][addr] = (ref_mem[r][addr] & ~m) | (s & m);
                else    ref_lb[r]        = (ref_lb[r] & ~m) | (s & m);
            end
        end
    endtask

    // Starts at a negedge; consecutive calls give back-to-back transfers.
    task automatic xfer(input logic sk, input int sr, input logic dk,
                        input logic [NROW-1:0] dr, input int addr,
                        input logic [NCOL-1:0] m);
        xfer_go = 1'b1; src_kind = sk; src_row = ROW_W'(sr);
        dst_kind = dk; dst_rows = dr; bit_addr = ADDR_W'(addr); col_mask = m;
        @(negedge clk);
        xfer_go = 1'b0;
        apply_ref(sk, sr, dk, dr, addr, m);
    endtask

    task automatic t_reset;
        for (int r = 0; r < NROW; r++) begin
            ref_lb[r] = '0;
            for (int a = 0; a < DEPTH; a++) ref_mem[r][a] = '0;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_lb_all("R1 state bits clear");
        check_mem_at(0, "R1 memory clear");
        check_mem_at(DEPTH - 1, "R1 memory clear");
    endtask

    task automatic t_load;
        for (int r = 0; r < NROW; r++) load(1'b0, r, 0, NCOL'(8'h11 * (r + 1)) ^ 8'h5A);
        for (int r = 0; r < NROW; r++) begin
            load(1'b1, r, 9,  NCOL'(8'h3C + r * 8'h17));
            load(1'b1, r, 10, NCOL'(8'hC3 ^ (r * 8'h21)));
            load(1'b1, r, 8,  NCOL'(8'h96 + r));
        end
        check_lb_all("R2 R10 load state rows");
        check_mem_at(9, "R2 R10 load memory rows");
        check_mem_at(10, "R2 load memory rows");
        check_mem_at(8, "R2 load memory rows");
        check_mem_at(11, "R2 untouched address");
    endtask

    task automatic t_lb_to_lb;
        @(negedge clk);
        xfer(1'b0, 2, 1'b0, 8'b0010_0000, 0, 8'hFF);
        check_lb_all("R3 state to state full mask");
    endtask

    task automatic t_mem_to_lb;
        @(negedge clk);
        xfer(1'b1, 6, 1'b0, 8'b0000_0010, 10, 8'hFF);
        check_lb_all("R4 memory to state");
    endtask

    task automatic t_masked;
        @(negedge clk);
        xfer(1'b1, 3, 1'b0, 8'b0000_1000 | 8'b0000_0001, 9, 8'b1010_0110);
        check_lb_all("R5 partial mask");
    endtask

    task automatic t_multi_mem;
        @(negedge clk);
        xfer(1'b0, 4, 1'b1, 8'b1101_0100, 9, 8'hFF);
        check_mem_at(9, "R6 R7 multi-row memory destination");
        check_mem_at(8, "R7 neighbour address below");
        check_mem_at(10, "R7 neighbour address above");
        check_lb_all("R7 state bits untouched");
    endtask

    task automatic t_chain;
        @(negedge clk);
        xfer(1'b0, 0, 1'b0, 8'b1000_0000, 0, 8'hFF);
        xfer(1'b0, 7, 1'b1, 8'b0000_0100, 10, 8'hFF);
        xfer(1'b1, 2, 1'b0, 8'b0100_0000, 10, 8'h0F);
        check_lb_all("R8 back-to-back chain");
        check_mem_at(10, "R8 back-to-back chain");
    endtask

    task automatic t_collide;
        @(negedge clk);
        ld_valid = 1'b1; ld_kind = 1'b0; ld_row = 3'd3; ld_addr = '0; ld_word = 8'hE7;
        xfer(1'b1, 5, 1'b0, 8'b0001_0000, 8, 8'hFF);
        ld_valid = 1'b0;
        check_lb_all("R9 load dropped under transfer");
    endtask

    task automatic t_noop;
        @(negedge clk);
        xfer(1'b1, 1, 1'b0, 8'h00, 9, 8'hFF);
        xfer(1'b0, 1, 1'b1, 8'hFF, 9, 8'h00);
        check_lb_all("R11 empty bitmap or mask");
        check_mem_at(9, "R11 empty bitmap or mask");
    endtask

    task automatic t_mem_to_mem;
        @(negedge clk);
        xfer(1'b1, 1, 1'b1, 8'b0110_0001, 8, 8'b0011_1100);
        check_mem_at(8, "R4 R5 memory to memory masked");
        check_mem_at(9, "R7 other address kept");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_load();
        t_lb_to_lb();
        t_mem_to_lb();
        t_masked();
        t_multi_mem();
        t_chain();
        t_collide();
        t_noop();
        t_mem_to_mem();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule